// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block gathers single-cycle event pulses from a serial flash controller's data path and turns them into sticky status bits. Two mask layers sit on top of the status: an enable mask decides which events are recorded at all, and a signal-enable mask decides which recorded and enabled bits may drive the single interrupt line. Two of the status bits are not fed from event pulses. They come from comparing the transmit and receive FIFO levels against 5-bit programmable thresholds.

Software reaches four registers through a simple word-wide register port. These are the status register (write 1 to clear), the enable mask, the signal-enable mask and the threshold register. Reads are registered and return one cycle after the request. A soft-reset input returns the configuration and the status to their reset values. An interrupt handler normally does one of two things with a source it has handled: it clears the status bit, or it removes the source's enable bit. Removing the enable bit silences the line even though the status bit stays set.

Top module: `irqc_top`

## Requirements
- R1: The status register (address 0) holds its bits at fixed positions: TX empty bit 0, TX full bit 1, TX threshold bit 2, RX empty bit 3, RX full bit 4, RX threshold bit 5, descriptor done bit 9, packet complete bit 10, DMA error bit 11. An event pulse on `src_evt_i[k]` maps to status bit k. All other status bits read 0.
- R2: An event whose enable bit is 1 sets its status bit at the next clock edge. The bit then stays set, with no further events, until it is cleared.
- R3: An event whose enable bit is 0 leaves its status bit unchanged.
- R4: Writing to address 0 clears each status bit written as 1 and leaves the bits written as 0 unchanged. When an enabled event arrives in the same cycle as a clear of its bit, the bit ends up set.
- R5: `irq_o` is 1 exactly when at least one bit is 1 in the status, enable (address 1) and signal-enable (address 2) registers together. Clearing an enable bit drops the line but keeps the status bit.
- R6: The TX threshold condition holds while `FIFO_DEPTH - tx_level_i` is at least the TX threshold. The TX threshold is bits 12:8 of address 3. While the condition holds and is enabled, it sets status bit 2.
- R7: The RX threshold condition holds while `rx_level_i` is at least the RX threshold. The RX threshold is bits 4:0 of address 3. While the condition holds and is enabled, it sets status bit 5.
- R8: Only the defined status positions (mask 0xE3F) can be written in the enable and signal-enable registers. Only bits 12:8 and 4:0 can be written in the threshold register. Every other bit reads 0. Read data appears on `rdata_o` with `rvalid_o` one cycle after `rd_en_i`.
- R9: A `soft_rst_i` pulse clears the status, enable and signal-enable registers and sets both thresholds to 1. It takes priority over a register write in the same cycle.
- R10: After `rst_ni` is released, status, enable and signal-enable read 0, the threshold register reads 0x0101, and `irq_o` is 0.
- R11: `src_evt_i` bits 2, 5, 6, 7 and 8 have no effect on the status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Synchronous soft reset pulse |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W (2) | Register address (0 status, 1 enable, 2 signal-enable, 3 thresholds) |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Registered read data |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_en_i |
| src_evt_i | input | 12 | Event pulses from the data path, one per status position |
| tx_level_i | input | LVL_W (5) | Transmit FIFO fill level, 0 to FIFO_DEPTH |
| rx_level_i | input | LVL_W (5) | Receive FIFO fill level, 0 to FIFO_DEPTH |
| irq_o | output | 1 | Interrupt line |

## Verification
The assertions check, on every cycle, the following properties:
- Each status bit holds while no clear or soft reset is present.
- An enabled event always lands in its status bit, even against a clear.
- A disabled event never creates a bit.
- Soft reset empties the status and the configuration.
- The interrupt line never rises without pending status and a non-zero signal-enable mask.

Only the bench's scenarios can show the following:
- The exact bit positions seen through the register port.
- The write masking of the configuration registers.
- The threshold boundaries, one level below and at the programmed value.
- The silencing of the line by removing an enable bit while the status is kept.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int STAT_W     = 12;
  localparam int THR_W      = 5;
  localparam int TX_THR_LSB = 8;
  localparam int RX_THR_LSB = 0;

  // status bit positions (decoded by software)
  localparam int B_TX_EMPTY = 0;
  localparam int B_TX_FULL  = 1;
  localparam int B_TX_THR   = 2;
  localparam int B_RX_EMPTY = 3;
  localparam int B_RX_FULL  = 4;
  localparam int B_RX_THR   = 5;
  localparam int B_DESC_END = 9;
  localparam int B_PKT_END  = 10;
  localparam int B_DMA_ERR  = 11;

  localparam logic [STAT_W-1:0] SRC_MASK =
    STAT_W'((1 << B_TX_EMPTY) | (1 << B_TX_FULL) | (1 << B_RX_EMPTY) |
            (1 << B_RX_FULL) | (1 << B_DESC_END) | (1 << B_PKT_END) |
            (1 << B_DMA_ERR));
  localparam logic [STAT_W-1:0] LVL_MASK =
    STAT_W'((1 << B_TX_THR) | (1 << B_RX_THR));
  localparam logic [STAT_W-1:0] VALID_MASK = SRC_MASK | LVL_MASK;

  localparam logic [THR_W-1:0] THR_RST = THR_W'(1);

  typedef enum logic [1:0] {
    A_STAT = 2'd0,
    A_EN   = 2'd1,
    A_SIG  = 2'd2,
    A_THR  = 2'd3
  } reg_addr_e;

  // free room in the transmit FIFO compared with the threshold
  function automatic logic tx_room_hit(input int unsigned depth,
                                       input int unsigned level,
                                       input int unsigned thr);
    int unsigned room;
    room = (level >= depth) ? 0 : depth - level;
    return room >= thr;
  endfunction

  // fill of the receive FIFO compared with the threshold
  function automatic logic rx_fill_hit(input int unsigned level,
                                       input int unsigned thr);
    return level >= thr;
  endfunction

endpackage

// File: rtl/irqc_thresh.sv
module irqc_thresh
  import irqc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [THR_W-1:0] tx_thr_i,
  input  logic [THR_W-1:0] rx_thr_i,
  output logic             tx_hit_o,
  output logic             rx_hit_o
);

  always_comb begin
    tx_hit_o = tx_room_hit(DEPTH, 32'(tx_level_i), 32'(tx_thr_i));
    rx_hit_o = rx_fill_hit(32'(rx_level_i), 32'(rx_thr_i));
  end

  // input ranges the comparisons rely on (R6, R7)
  p_tx_level_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(tx_level_i) <= DEPTH);
  p_rx_level_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(rx_level_i) <= DEPTH);

endmodule

// File: rtl/irqc_cfg.sv
module irqc_cfg
  import irqc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              wr_en_i,
  input  logic              wr_sig_i,
  input  logic              wr_thr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [STAT_W-1:0] en_o,
  output logic [STAT_W-1:0] sig_o,
  output logic [THR_W-1:0]  tx_thr_o,
  output logic [THR_W-1:0]  rx_thr_o
);

  localparam int USED_TOP = TX_THR_LSB + THR_W;

  logic [STAT_W-1:0] en_q, sig_q;
  logic [THR_W-1:0]  tx_thr_q, rx_thr_q;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^wdata_i[DATA_W-1:USED_TOP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      sig_q    <= '0;
      tx_thr_q <= THR_RST;
      rx_thr_q <= THR_RST;
    end else if (srst_i) begin
      en_q     <= '0;
      sig_q    <= '0;
      tx_thr_q <= THR_RST;
      rx_thr_q <= THR_RST;
    end else begin
      if (wr_en_i)  en_q  <= wdata_i[STAT_W-1:0] & VALID_MASK;
      if (wr_sig_i) sig_q <= wdata_i[STAT_W-1:0] & VALID_MASK;
      if (wr_thr_i) begin
        tx_thr_q <= wdata_i[TX_THR_LSB +: THR_W];
        rx_thr_q <= wdata_i[RX_THR_LSB +: THR_W];
      end
    end
  end

  assign en_o     = en_q;
  assign sig_o    = sig_q;
  assign tx_thr_o = tx_thr_q;
  assign rx_thr_o = rx_thr_q;

  // R9: soft reset restores the configuration even against a write
  p_cfg_srst_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (en_q == '0) && (sig_q == '0) &&
               (tx_thr_q == THR_RST) && (rx_thr_q == THR_RST));
  // R8: configuration only moves on a write or soft reset
  p_cfg_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && !wr_en_i && !wr_sig_i && !wr_thr_i) |=>
      $stable(en_q) && $stable(sig_q) && $stable(tx_thr_q) && $stable(rx_thr_q));
  // R8: undefined positions never appear in the masks
  p_cfg_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en_q | sig_q) & ~VALID_MASK) == '0);

endmodule

// File: rtl/irqc_status_bank.sv
module irqc_status_bank
  import irqc_pkg::*;
#(
  parameter int              W    = STAT_W,
  parameter logic [W-1:0]    KEEP = VALID_MASK
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);

  logic [W-1:0] nxt;
  logic [W-1:0] q;
  logic         unused_nxt;

  // set beats clear: an enabled event lands even when its bit is cleared
  always_comb nxt = srst_i ? '0 : ((q & ~clr_i) | (evt_i & en_i));

  assign unused_nxt = ^(nxt & ~KEEP);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (KEEP[i]) begin : g_flop
      logic b_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) b_q <= 1'b0;
        else         b_q <= nxt[i];
      end
      assign q[i] = b_q;

      // R2: a set bit stays set until cleared
      p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (b_q && !clr_i[i] && !srst_i) |=> b_q);
      // R2 and R4: an enabled event is recorded, also against a clear
      p_event_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i[i] && en_i[i] && !srst_i) |=> b_q);
      // R3: nothing appears without an enabled event
      p_no_record_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!b_q && !(evt_i[i] && en_i[i])) |=> !b_q);
      // R9: soft reset empties the bit
      p_stat_srst_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        srst_i |=> !b_q);
    end else begin : g_tie
      assign q[i] = 1'b0;
    end
  end

  assign stat_o = q;

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 2,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  input  logic [STAT_W-1:0] src_evt_i,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  output logic              irq_o
);

  localparam int GAP_W = TX_THR_LSB - THR_W;

  // decoded write strobes
  logic wr_stat, wr_en, wr_sig, wr_thr;
  assign wr_stat = wr_en_i && (addr_i == ADDR_W'(A_STAT));
  assign wr_en   = wr_en_i && (addr_i == ADDR_W'(A_EN));
  assign wr_sig  = wr_en_i && (addr_i == ADDR_W'(A_SIG));
  assign wr_thr  = wr_en_i && (addr_i == ADDR_W'(A_THR));

  logic [STAT_W-1:0] en_q, sig_q, stat_q, raw_evt, clr_mask;
  logic [THR_W-1:0]  tx_thr_q, rx_thr_q;
  logic              tx_hit, rx_hit;

  irqc_cfg #(.DATA_W(DATA_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .srst_i   (soft_rst_i),
    .wr_en_i  (wr_en),
    .wr_sig_i (wr_sig),
    .wr_thr_i (wr_thr),
    .wdata_i  (wdata_i),
    .en_o     (en_q),
    .sig_o    (sig_q),
    .tx_thr_o (tx_thr_q),
    .rx_thr_o (rx_thr_q)
  );

  irqc_thresh #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_thresh (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_level_i (tx_level_i),
    .rx_level_i (rx_level_i),
    .tx_thr_i   (tx_thr_q),
    .rx_thr_i   (rx_thr_q),
    .tx_hit_o   (tx_hit),
    .rx_hit_o   (rx_hit)
  );

  // data-path pulses on their own positions, level conditions on theirs
  always_comb begin
    raw_evt           = src_evt_i & SRC_MASK;
    raw_evt[B_TX_THR] = tx_hit;
    raw_evt[B_RX_THR] = rx_hit;
  end

  assign clr_mask = wr_stat ? wdata_i[STAT_W-1:0] : '0;

  irqc_status_bank #(.W(STAT_W), .KEEP(VALID_MASK)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .srst_i (soft_rst_i),
    .evt_i  (raw_evt),
    .en_i   (en_q),
    .clr_i  (clr_mask),
    .stat_o (stat_q)
  );

  // interrupt line: status, enable and signal gate must all agree
  assign irq_o = |(stat_q & en_q & sig_q);

  // registered read port
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              rvalid_q;

  always_comb begin
    rdata_d = '0;
    unique case (addr_i)
      ADDR_W'(A_STAT): rdata_d = DATA_W'(stat_q);
      ADDR_W'(A_EN):   rdata_d = DATA_W'(en_q);
      ADDR_W'(A_SIG):  rdata_d = DATA_W'(sig_q);
      default:         rdata_d = DATA_W'({tx_thr_q, {GAP_W{1'b0}}, rx_thr_q});
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en_i;
      if (rd_en_i) rdata_q <= rdata_d;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  // R5: the line needs pending status and an open signal gate
  p_irq_needs_status_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (stat_q != '0));
  p_irq_needs_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sig_q == '0) |-> !irq_o);
  // R8: read data valid exactly one cycle after the request
  p_rvalid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o);
  p_rvalid_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rvalid_o);
  // R9: soft reset drops the line
  p_irq_srst_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !irq_o);

endmodule

// File: tb/test_irqc_top.sv
`timescale 1ns/1ps
module test_irqc_top;

  localparam int DEPTH = 16;
  localparam int LW    = $clog2(DEPTH + 1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        srst = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [11:0] src_evt = '0;
  logic [LW-1:0] tx_level = LW'(DEPTH);
  logic [LW-1:0] rx_level = '0;
  logic        irq;

  int checks = 0;
  int failures = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  irqc_top #(.FIFO_DEPTH(DEPTH)) i_irqc_top (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .soft_rst_i (srst),
    .wr_en_i    (wr_en),
    .rd_en_i    (rd_en),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .rvalid_o   (rvalid),
    .src_evt_i  (src_evt),
    .tx_level_i (tx_level),
    .rx_level_i (rx_level),
    .irq_o      (irq)
  );

  // monitor: pops the scoreboard on every returned read
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R8 unexpected read data: actual=%h expected=none", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          failures++;
          $display("FAIL %s: actual=%h expected=%h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [11:0] m);
    @(negedge clk);
    src_evt = m;
    @(negedge clk);
    src_evt = '0;
  endtask

  task automatic wr_with_evt(input logic [1:0] a, input logic [31:0] d,
                             input logic [11:0] m);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; src_evt = m;
    @(negedge clk);
    wr_en = 1'b0; src_evt = '0;
  endtask

  task automatic soft_reset_with_write();
    @(negedge clk);
    srst = 1'b1; wr_en = 1'b1; addr = 2'd1; wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    srst = 1'b0; wr_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      failures++;
      $display("FAIL %s irq: actual=%b expected=%b", t, irq, e);
    end
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk_irq(1'b0, "R10 reset");
    rd(2'd0, 32'h0, "R10 status");
    rd(2'd1, 32'h0, "R10 enable");
    rd(2'd2, 32'h0, "R10 signal-enable");
    rd(2'd3, 32'h0101, "R10 thresholds");

    // R8 register masking; thresholds made unreachable
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, 32'h1F1F, "R8 threshold fields");
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, 32'h0E3F, "R8 enable mask");
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, 32'h0E3F, "R8 signal-enable mask");

    // R2 record and sticky
    pulse(12'h001);
    rd(2'd0, 32'h001, "R2 record");
    chk_irq(1'b1, "R5 line raised");
    repeat (5) @(negedge clk);
    rd(2'd0, 32'h001, "R2 sticky");

    // R4 write one to clear
    wr(2'd0, 32'h0);
    rd(2'd0, 32'h001, "R4 zero write keeps");
    wr(2'd0, 32'h1);
    rd(2'd0, 32'h0, "R4 clear");
    chk_irq(1'b0, "R5 line dropped");

    // R1 bit positions
    pulse(12'hE1B);
    rd(2'd0, 32'hE1B, "R1 positions");
    wr(2'd0, 32'hFFF);
    rd(2'd0, 32'h0, "R4 clear all");

    // R3 disabled source
    wr(2'd1, 32'h0E2F);
    pulse(12'h010);
    rd(2'd0, 32'h0, "R3 disabled not recorded");
    chk_irq(1'b0, "R3 no line");

    // R11 ignored input positions
    pulse(12'h1E4);
    rd(2'd0, 32'h0, "R11 ignored inputs");

    // R4 event wins over clear
    pulse(12'h200);
    wr_with_evt(2'd0, 32'h200, 12'h200);
    rd(2'd0, 32'h200, "R4 event wins");

    // R5 signal gate and silencing by enable
    wr(2'd2, 32'h400);
    chk_irq(1'b0, "R5 gate closed");
    pulse(12'h400);
    chk_irq(1'b1, "R5 gate open");
    rd(2'd0, 32'h600, "R5 status");
    wr(2'd1, 32'h002F);
    chk_irq(1'b0, "R5 silenced");
    rd(2'd0, 32'h600, "R5 status kept");

    wr(2'd1, 32'h0E3F);
    wr(2'd2, 32'h0E3F);
    wr(2'd0, 32'hFFF);

    // R6 TX room threshold = 4
    wr(2'd3, 32'h0405);
    rd(2'd0, 32'h0, "R6 idle");
    tx_level = LW'(13);
    repeat (2) @(negedge clk);
    rd(2'd0, 32'h0, "R6 room 3 below");
    tx_level = LW'(12);
    @(negedge clk);
    rd(2'd0, 32'h004, "R6 room 4 at");
    chk_irq(1'b1, "R6 line");
    tx_level = LW'(DEPTH);
    wr(2'd0, 32'h004);
    rd(2'd0, 32'h0, "R6 cleared");

    // R7 RX fill threshold = 5
    rx_level = LW'(4);
    repeat (2) @(negedge clk);
    rd(2'd0, 32'h0, "R7 fill 4 below");
    rx_level = LW'(5);
    @(negedge clk);
    rd(2'd0, 32'h020, "R7 fill 5 at");
    rx_level = '0;
    wr(2'd0, 32'h020);
    rd(2'd0, 32'h0, "R7 cleared");

    // R9 soft reset beats a write
    pulse(12'h801);
    chk_irq(1'b1, "R9 before");
    soft_reset_with_write();
    chk_irq(1'b0, "R9 line");
    rd(2'd0, 32'h0, "R9 status");
    rd(2'd1, 32'h0, "R9 enable");
    rd(2'd2, 32'h0, "R9 signal-enable");
    rd(2'd3, 32'h0101, "R9 thresholds");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R8 missing reads: actual=%0d expected=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule